// File: doc/BRIEF.md
# Serial Multidrop Command Controller

This block sits on a control bus that many power-management chips share. It takes a serial bit stream, one bit per cycle in which a valid strobe is high, and finds fixed 32-bit command words in it. Each word opens with a fixed marker and closes with a fixed end pattern. It carries a chip address, a register address, an operation code and a data byte. A word is acted on only when its chip address equals the strapped local ID and its register address falls inside the implemented register file.

The register file holds byte-wide configuration registers. The low nibbles of the first five drive the shunt voltage select, the two regulator voltage selects, the ADC step tune and the alarm delay tune. Every register can be cleared, filled with ones, returned to its hard-coded default, or written with the data byte. A read operation captures the current monitoring ADC code and sends it back as a byte on a reply line. The reply line has an output enable, so only the addressed chip ever drives the shared return wire.

Top module: `smc_cmd_ctrl`

## Requirements
- R1: Words arrive MSB first. Bits 31:25 are the marker 1100111, bits 24:20 the chip address, bits 19:15 the register address, bits 14:12 the operation, bits 11:4 the data byte, and bits 3:0 the end pattern 0000.
- R2: After reset every register holds its default: register 0 (shunt select, lowest voltage) = 0x00, registers 1 and 2 (regulator selects) = 0x03, register 3 (ADC step) = 0x0F, register 4 (alarm delay) = 0x08, and all others = 0x00. The reply enable is low.
- R3: Operation 011 writes the data byte into the addressed register.
- R4: Operation 000 clears the addressed register to 0x00 and leaves the other registers unchanged.
- R5: Operation 001 sets the addressed register to 0xFF.
- R6: Operation 010 restores only the addressed register to its R2 default.
- R7: Operations 101, 110 and 111 change no register.
- R8: A word whose chip address differs from the strap changes no register.
- R9: A word whose register address is NREG or above changes no register.
- R10: A word with a wrong marker or end pattern is discarded. The receiver keeps sliding bit by bit, so a correct word that follows stray bits or a bad word is still accepted.
- R11: Operation 100 latches the ADC code and returns it as 8 bits, zero-padded at the top, MSB first, one bit per clock. The first bit appears in the second cycle after the last command bit is taken, and the enable stays high for exactly 8 cycles.
- R12: The reply enable stays low unless a read addressed to this chip is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| chip_id_i | input | 5 | Strapped local chip address |
| sdi_i | input | 1 | Serial command bit |
| sdi_vld_i | input | 1 | Command bit strobe |
| adc_code_i | input | 6 | Sampled monitoring ADC code |
| sdo_o | output | 1 | Reply data bit |
| sdo_oe_o | output | 1 | Reply line drive enable |
| cfg_o | output | NREG*8 | Whole register file, register i in bits 8i+7:8i |
| shunt_vsel_o | output | 4 | Shunt voltage select |
| ldo_a_vsel_o | output | 4 | First regulator voltage select |
| ldo_b_vsel_o | output | 4 | Second regulator voltage select |
| adc_step_o | output | 4 | ADC step tune |
| alarm_dly_o | output | 4 | Alarm delay tune |

## Verification
The bench builds the block with its default NREG of 20 and a 6-bit ADC code. With these values register 19 is the last one in range, and addresses 20 and 31 exercise the range guard. The strap is set to 21, and commands are sent to both 21 and 20. The words used for the resynchronisation test avoid runs of four zeros ahead of their end pattern, so when the receiver slides over stray bits, the true word end is the only window that can match.

// File: rtl/smc_pkg.sv
package smc_pkg;

  localparam logic [6:0] FRAME_MARK = 7'b1100111;
  localparam logic [3:0] FRAME_END  = 4'b0000;

  typedef enum logic [2:0] {
    OP_CLR = 3'b000,
    OP_SET = 3'b001,
    OP_DEF = 3'b010,
    OP_WR  = 3'b011,
    OP_ADC = 3'b100
  } op_e;

  // Power-on value of register idx
  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      0:       return 8'h00;  // shunt select: lowest voltage
      1, 2:    return 8'h03;  // regulator selects
      3:       return 8'h0F;  // ADC step tune
      4:       return 8'h08;  // alarm delay tune
      default: return 8'h00;
    endcase
  endfunction

  // Next value of one register for an operation
  function automatic logic [7:0] reg_next(logic [2:0] op, logic [7:0] data,
                                          logic [7:0] dflt, logic [7:0] cur);
    case (op)
      OP_CLR:  return 8'h00;
      OP_SET:  return 8'hFF;
      OP_DEF:  return dflt;
      OP_WR:   return data;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/smc_deframer.sv
module smc_deframer #(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  output logic       frame_vld_o,
  output logic [4:0] chip_o,
  output logic [4:0] reg_o,
  output logic [2:0] op_o,
  output logic [7:0] data_o
);
  import smc_pkg::*;

  localparam int FW = $clog2(W + 1);

  logic [W-1:0]  win_q, win_next;
  logic [FW-1:0] fill_q;
  logic          frame_hit;
  logic          vld_q;

  assign win_next  = {win_q[W-2:0], bit_i};
  assign frame_hit = bit_vld_i && (fill_q >= FW'(W - 1)) &&
                     (win_next[W-1:W-7] == FRAME_MARK) &&
                     (win_next[3:0] == FRAME_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= frame_hit;
      if (bit_vld_i) begin
        win_q <= win_next;
        if (frame_hit)                  fill_q <= '0;
        else if (fill_q != FW'(W - 1))  fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign frame_vld_o = vld_q;
  assign chip_o      = win_q[24:20];
  assign reg_o       = win_q[19:15];
  assign op_o        = win_q[14:12];
  assign data_o      = win_q[11:4];

  // a full word needs W new bits, so two frames never touch
  assert_frame_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |=> !frame_vld_o);
  assert_frame_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld_o |-> $past(bit_vld_i));

endmodule

// File: rtl/smc_regfile.sv
module smc_regfile #(
  parameter int NREG = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [4:0]        addr_i,
  input  logic [2:0]        op_i,
  input  logic [7:0]        data_i,
  output logic [NREG*8-1:0] regs_o
);
  import smc_pkg::*;

  logic [7:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= reg_default(g);
      else if (wr_en_i && addr_i == 5'(g))
        regs_q[g] <= reg_next(op_i, data_i, reg_default(g), regs_q[g]);
    end
    assign regs_o[g*8 +: 8] = regs_q[g];
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(regs_o));
  assert_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_i == OP_WR) |=> regs_q[$past(addr_i)] == $past(data_i));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_i == OP_CLR) |=> regs_q[$past(addr_i)] == 8'h00);
  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_i == OP_SET) |=> regs_q[$past(addr_i)] == 8'hFF);

endmodule

// File: rtl/smc_reply.sv
module smc_reply #(
  parameter int DW   = 8,
  parameter int ADCW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [ADCW-1:0] adc_i,
  output logic            sdo_o,
  output logic            sdo_oe_o
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          oe_q;
  logic          reply_start;

  assign reply_start = load_i && !oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (reply_start) begin
      sh_q  <= DW'(adc_i);
      cnt_q <= '0;
      oe_q  <= 1'b1;
    end else if (oe_q) begin
      if (cnt_q == CW'(DW - 1)) begin
        oe_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= {sh_q[DW-2:0], 1'b0};
      end
    end
  end

  assign sdo_o    = oe_q & sh_q[DW-1];
  assign sdo_oe_o = oe_q;

  assert_oe_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> $past(load_i));
  assert_oe_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && cnt_q != CW'(DW - 1)) |=> sdo_oe_o);
  assert_pad_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sdo_oe_o) && DW > ADCW) |-> !sdo_o);

endmodule

// File: rtl/smc_cmd_ctrl.sv
module smc_cmd_ctrl #(
  parameter int NREG = 20,
  parameter int ADCW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        chip_id_i,
  input  logic              sdi_i,
  input  logic              sdi_vld_i,
  input  logic [ADCW-1:0]   adc_code_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [NREG*8-1:0] cfg_o,
  output logic [3:0]        shunt_vsel_o,
  output logic [3:0]        ldo_a_vsel_o,
  output logic [3:0]        ldo_b_vsel_o,
  output logic [3:0]        adc_step_o,
  output logic [3:0]        alarm_dly_o
);
  import smc_pkg::*;

  localparam int WORD_W = 32;

  logic       frame_vld;
  logic [4:0] f_chip, f_reg;
  logic [2:0] f_op;
  logic [7:0] f_data;
  logic       chip_ok, addr_ok, cmd_accept, reg_wr, adc_load;

  smc_deframer #(.W(WORD_W)) deframer_i (
    .clk(clk), .rst_n(rst_n), .bit_i(sdi_i), .bit_vld_i(sdi_vld_i),
    .frame_vld_o(frame_vld), .chip_o(f_chip), .reg_o(f_reg),
    .op_o(f_op), .data_o(f_data)
  );

  assign chip_ok    = (f_chip == chip_id_i);
  assign addr_ok    = (32'(f_reg) < NREG);
  assign cmd_accept = frame_vld && chip_ok && addr_ok;
  assign reg_wr     = cmd_accept && (f_op[2] == 1'b0);
  assign adc_load   = cmd_accept && (f_op == OP_ADC);

  smc_regfile #(.NREG(NREG)) regfile_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr), .addr_i(f_reg),
    .op_i(f_op), .data_i(f_data), .regs_o(cfg_o)
  );

  smc_reply #(.DW(8), .ADCW(ADCW)) reply_i (
    .clk(clk), .rst_n(rst_n), .load_i(adc_load), .adc_i(adc_code_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  assign shunt_vsel_o = cfg_o[3:0];
  assign ldo_a_vsel_o = cfg_o[11:8];
  assign ldo_b_vsel_o = cfg_o[19:16];
  assign adc_step_o   = cfg_o[27:24];
  assign alarm_dly_o  = cfg_o[35:32];

  assert_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !chip_ok) |=> $stable(cfg_o));
  assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !addr_ok) |=> $stable(cfg_o));

endmodule

// File: tb/smc_cmd_ctrl_tb.sv
module smc_cmd_ctrl_tb_top;
  localparam int NREG = 20;
  localparam logic [4:0] MY_ID = 5'd21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi = 1'b0, sdi_vld = 1'b0;
  logic [5:0] adc = '0;
  logic sdo, sdo_oe;
  logic [NREG*8-1:0] cfg;
  logic [3:0] shunt_v, ldo_a, ldo_b, adc_step, alarm_dly;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  smc_cmd_ctrl #(.NREG(NREG), .ADCW(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_id_i(MY_ID), .sdi_i(sdi),
    .sdi_vld_i(sdi_vld), .adc_code_i(adc), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .cfg_o(cfg), .shunt_vsel_o(shunt_v), .ldo_a_vsel_o(ldo_a),
    .ldo_b_vsel_o(ldo_b), .adc_step_o(adc_step), .alarm_dly_o(alarm_dly)
  );

  function automatic logic [7:0] exp_default(int i);
    if (i == 1 || i == 2) return 8'h03;
    if (i == 3) return 8'h0F;
    if (i == 4) return 8'h08;
    return 8'h00;
  endfunction

  function automatic logic [31:0] mk(logic [4:0] chip, logic [4:0] r, logic [2:0] op,
                                     logic [7:0] d);
    return {7'b1100111, chip, r, op, d, 4'b0000};
  endfunction

  function automatic logic [7:0] rd(int i);
    return cfg[i*8 +: 8];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    for (int b = n - 1; b >= 0; b--) begin
      @(negedge clk);
      sdi = w[b];
      sdi_vld = 1'b1;
    end
  endtask

  task automatic send(logic [31:0] w);
    send_bits(w, 32);
    @(negedge clk);
    sdi_vld = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) chk("R2 default", 32'(rd(i)), 32'(exp_default(i)));
    chk("R2 shunt select", 32'(shunt_v), 32'h0);
    chk("R2 alarm delay", 32'(alarm_dly), 32'h8);
    chk("R12 idle enable", 32'(sdo_oe), 32'h0);
  endtask

  task automatic t_write();
    send(mk(MY_ID, 5'd7, 3'b011, 8'h5A)); settle();
    chk("R3 write reg7", 32'(rd(7)), 32'h5A);
    send(mk(MY_ID, 5'd1, 3'b011, 8'hC6)); settle();
    chk("R1 field layout ldo_a", 32'(ldo_a), 32'h6);
    chk("R3 write reg1", 32'(rd(1)), 32'hC6);
  endtask

  task automatic t_clear_set();
    send(mk(MY_ID, 5'd3, 3'b000, 8'h77)); settle();
    chk("R4 clear reg3", 32'(rd(3)), 32'h00);
    chk("R4 neighbour reg4", 32'(rd(4)), 32'h08);
    send(mk(MY_ID, 5'd19, 3'b001, 8'h00)); settle();
    chk("R5 set last reg", 32'(rd(19)), 32'hFF);
  endtask

  task automatic t_default();
    send(mk(MY_ID, 5'd2, 3'b011, 8'h77)); settle();
    send(mk(MY_ID, 5'd1, 3'b010, 8'h00)); settle();
    chk("R6 restore reg1", 32'(rd(1)), 32'h03);
    chk("R6 reg2 untouched", 32'(rd(2)), 32'h77);
  endtask

  task automatic t_illegal();
    for (int op = 5; op < 8; op++) begin
      send(mk(MY_ID, 5'd7, 3'(op), 8'h11)); settle();
      chk("R7 unused op", 32'(rd(7)), 32'h5A);
    end
  endtask

  task automatic t_foreign();
    send(mk(5'd20, 5'd7, 3'b011, 8'h22)); settle();
    chk("R8 foreign write", 32'(rd(7)), 32'h5A);
    adc = 6'h3F;
    send(mk(5'd20, 5'd0, 3'b100, 8'h00));
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk("R12 foreign read enable", 32'(sdo_oe), 32'h0);
    end
  endtask

  task automatic t_range();
    send(mk(MY_ID, 5'd20, 3'b011, 8'h33)); settle();
    send(mk(MY_ID, 5'd31, 3'b001, 8'h00)); settle();
    for (int i = 0; i < NREG; i++)
      if (i != 1 && i != 2 && i != 3 && i != 7 && i != 19)
        chk("R9 out of range", 32'(rd(i)), 32'(exp_default(i)));
  endtask

  task automatic t_hunt();
    logic [31:0] good;
    good = mk(MY_ID, 5'd3, 3'b011, 8'hA5);
    send(mk(MY_ID, 5'd3, 3'b000, 8'h00)); settle();
    send(good | 32'h1); settle();
    chk("R10 bad end pattern", 32'(rd(3)), 32'h00);
    send(good & ~32'h8000_0000); settle();
    chk("R10 bad marker", 32'(rd(3)), 32'h00);
    send_bits(32'b101, 3);
    send(good); settle();
    chk("R10 resync after stray bits", 32'(rd(3)), 32'hA5);
  endtask

  task automatic t_adc(logic [5:0] code);
    logic [7:0] exp;
    exp = {2'b00, code};
    adc = code;
    send(mk(MY_ID, 5'd0, 3'b100, 8'h00));
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk);
      chk("R11 reply enable", 32'(sdo_oe), 32'h1);
      chk("R11 reply bit", 32'(sdo), 32'(exp[b]));
    end
    @(negedge clk);
    chk("R12 enable drops", 32'(sdo_oe), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_clear_set();
    t_default();
    t_illegal();
    t_foreign();
    t_range();
    t_hunt();
    t_adc(6'b101101);
    t_adc(6'b111111);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule